// File: doc/BRIEF.md
# Dual-Output Vectored Interrupt Controller

This block collects 64 level-sensitive interrupt sources. For each source it holds a pending bit, an enable bit and a type bit. The type bit sends the source either to a fast interrupt line or to a normal interrupt line. Every source also has a 4-bit priority. The normal line is filtered by a 5-bit threshold. When the threshold holds all ones, filtering is off and any qualifying normal source raises the line.

Software reaches the block through a simple 32-bit port with word addresses. Read data is combinational while a read is selected, and side effects take place on the clock edge that ends the access. There are two vector words. Reading either one returns the winning source for its line and acknowledges it by clearing its pending bit. The other words give access to the enables, the types and the priorities, and provide force and pending views.

Top module: `irqc_top`

## Requirements
- R1: After reset the pending, enable and type vectors, all priorities and the control word are zero, the threshold reads 0x1F, and both outputs are low.
- R2: The fast output goes high one clock after the state has a source that is pending, enabled and has type bit 1.
- R3: With threshold 0x1F, the normal output goes high one clock after any source that is pending, enabled and has type bit 0, whatever its priority (priority 0 included).
- R4: With any other threshold, the normal output is high only when such a source has a priority strictly greater than the threshold.
- R5: A write to word 2 sets the enable bit indexed by data[5:0]. A write to word 3 clears it. Both words read 0.
- R6: Words 4/5 are the high/low halves of the enable vector and words 6/7 the high/low halves of the type vector. Each half is read and written without disturbing the other half.
- R7: Words 8..15 each hold eight 4-bit priorities. Word 15 holds sources 0..7 and word 8 holds sources 56..63. Source n occupies bits 4*(n mod 8)+3 : 4*(n mod 8). Reads return the written value.
- R8: A read of word 16 returns (source<<16)|priority for the highest-priority source that is pending, enabled and normal. Ties go to the higher source number. The read clears that pending bit. It returns 0xFFFFFFFF if no source qualifies.
- R9: A read of word 17 returns the lowest-numbered source that is pending, enabled and fast, and clears its pending bit. It returns 0xFFFFFFFF if there is none.
- R10: Words 18/19 read the raw pending halves. Words 20/21 read 0, and a write loads the matching pending half. Words 22/23 read pending&enabled&normal and words 24/25 read pending&enabled&fast. Writes to words 16..19 and 22..25 change nothing.
- R11: A read of word 0x40 returns 4. Writes to words 0x40..0xBF change nothing and those words, other than 0x40, read 0.
- R12: A high source level sets its pending bit at the next clock, and a falling level clears it. If an acknowledge clears a bit while its level is high, the clear wins for that cycle and the bit is set again one clock later.
- R13: Word 0 is the control word: it stores the low CTRL_W bits of the written data and reads them back.
- R14: Word 1 stores data[4:0] as the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | 64 | Interrupt source levels |
| busSel | input | 1 | Access select for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while a read is selected |
| irqOut | output | 1 | Registered normal interrupt line |
| fiqOut | output | 1 | Registered fast interrupt line |

## Verification
The hardest case to reach is the race in which an acknowledging read clears a pending bit in the same cycle that the source level is still high. The stimulus holds the source high, reads the fast vector word, and reads the raw pending word in the very next cycle with no idle cycle between. It expects the bit to be clear in that cycle and set again one access later. Priority ties also need care: two sources with equal priority, plus a lower-priority third source, are forced pending through the force words. A chain of vector reads must then drain them in the order higher index, lower index, lower priority, followed by the empty code.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_N      = 64;
  localparam int DATA_W     = 32;
  localparam int PRIO_W     = 4;
  localparam int THR_W      = 5;
  localparam int IDX_W      = $clog2(SRC_N);
  localparam int PRIO_PER   = DATA_W / PRIO_W;
  localparam int PRIO_WORDS = SRC_N / PRIO_PER;
  localparam int PIDX_W     = $clog2(PRIO_WORDS);

  typedef enum logic [4:0] {
    RS_ZERO, RS_CTRL, RS_THR, RS_EN_HI, RS_EN_LO, RS_TY_HI, RS_TY_LO,
    RS_PRIO, RS_NORM_VEC, RS_FAST_VEC, RS_PEND_HI, RS_PEND_LO,
    RS_NPEND_HI, RS_NPEND_LO, RS_FPEND_HI, RS_FPEND_LO, RS_CONST4
  } rdSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrThr;
    logic enSet;
    logic enClr;
    logic wrEnHi;
    logic wrEnLo;
    logic wrTyHi;
    logic wrTyLo;
    logic wrPrio;
    logic wrForceHi;
    logic wrForceLo;
    logic ackNorm;
    logic ackFast;
    logic [PIDX_W-1:0] prioIdx;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam int W_PRIO_FIRST = 8;
  localparam int W_PRIO_LAST  = W_PRIO_FIRST + PRIO_WORDS - 1;
  localparam int W_VEC_FIRST  = 'h40;
  localparam int W_VEC_LAST   = 'hBF;

  int wordNum;
  logic isRd, isWr;

  assign wordNum = int'(busAddr);
  assign isRd = busSel && !busWr;
  assign isWr = busSel && busWr;

  always_comb begin
    stb = '0;
    stb.rdSel = RS_ZERO;
    if (wordNum >= W_PRIO_FIRST && wordNum <= W_PRIO_LAST)
      stb.prioIdx = PIDX_W'(W_PRIO_LAST - wordNum);
    if (isWr) begin
      case (wordNum)
        0:  stb.wrCtrl    = 1'b1;
        1:  stb.wrThr     = 1'b1;
        2:  stb.enSet     = 1'b1;
        3:  stb.enClr     = 1'b1;
        4:  stb.wrEnHi    = 1'b1;
        5:  stb.wrEnLo    = 1'b1;
        6:  stb.wrTyHi    = 1'b1;
        7:  stb.wrTyLo    = 1'b1;
        20: stb.wrForceHi = 1'b1;
        21: stb.wrForceLo = 1'b1;
        default: stb.wrPrio = (wordNum >= W_PRIO_FIRST && wordNum <= W_PRIO_LAST);
      endcase
    end
    if (isRd) begin
      case (wordNum)
        0:  stb.rdSel = RS_CTRL;
        1:  stb.rdSel = RS_THR;
        4:  stb.rdSel = RS_EN_HI;
        5:  stb.rdSel = RS_EN_LO;
        6:  stb.rdSel = RS_TY_HI;
        7:  stb.rdSel = RS_TY_LO;
        16: begin stb.rdSel = RS_NORM_VEC; stb.ackNorm = 1'b1; end
        17: begin stb.rdSel = RS_FAST_VEC; stb.ackFast = 1'b1; end
        18: stb.rdSel = RS_PEND_HI;
        19: stb.rdSel = RS_PEND_LO;
        22: stb.rdSel = RS_NPEND_HI;
        23: stb.rdSel = RS_NPEND_LO;
        24: stb.rdSel = RS_FPEND_HI;
        25: stb.rdSel = RS_FPEND_LO;
        W_VEC_FIRST: stb.rdSel = RS_CONST4;
        default: stb.rdSel = (wordNum >= W_PRIO_FIRST && wordNum <= W_PRIO_LAST) ? RS_PRIO : RS_ZERO;
      endcase
    end
  end

  logic anyWrStb;
  assign anyWrStb = stb.wrCtrl | stb.wrThr | stb.enSet | stb.enClr | stb.wrEnHi |
                    stb.wrEnLo | stb.wrTyHi | stb.wrTyLo | stb.wrPrio |
                    stb.wrForceHi | stb.wrForceLo;

  AST_RO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && ((wordNum >= 16 && wordNum <= 19) || (wordNum >= 22 && wordNum <= 25)))
      |-> !anyWrStb); // R10

  AST_VECTOR_REGION_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (isWr && wordNum >= W_VEC_FIRST && wordNum <= W_VEC_LAST) |-> !anyWrStb); // R11

  AST_ACK_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackNorm || stb.ackFast) |-> (busSel && !busWr && !anyWrStb)); // R8
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  srcLevel,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              fiqOut
);
  localparam int HALF = SRC_N / 2;
  localparam logic [THR_W-1:0] THR_OFF = '1;

  logic [SRC_N-1:0]  pendQ, enQ, tyQ, srcQ;
  logic [SRC_N-1:0]  pendD, enD, tyD;
  logic [THR_W-1:0]  thrQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic [DATA_W-1:0] prioQ [PRIO_WORDS];

  logic [SRC_N-1:0]  liveVec, normVec, fastVec, aboveThr;
  logic [PRIO_W-1:0] srcPrio [SRC_N];

  assign liveVec = pendQ & enQ;
  assign normVec = liveVec & ~tyQ;
  assign fastVec = liveVec & tyQ;

  for (genvar n = 0; n < SRC_N; n++) begin : gPrio
    assign srcPrio[n]  = prioQ[n / PRIO_PER][PRIO_W * (n % PRIO_PER) +: PRIO_W];
    assign aboveThr[n] = {1'b0, srcPrio[n]} > thrQ;
  end

  // Normal winner: highest priority, later index wins ties.
  logic              normHit;
  logic [IDX_W-1:0]  normIdx;
  logic [PRIO_W-1:0] normPri;
  always_comb begin
    normHit = 1'b0;
    normIdx = '0;
    normPri = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (normVec[i] && (!normHit || srcPrio[i] >= normPri)) begin
        normHit = 1'b1;
        normIdx = IDX_W'(i);
        normPri = srcPrio[i];
      end
    end
  end

  // Fast winner: lowest index.
  logic             fastHit;
  logic [IDX_W-1:0] fastIdx;
  always_comb begin
    fastHit = 1'b0;
    fastIdx = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (fastVec[i]) begin
        fastHit = 1'b1;
        fastIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    pendD = (pendQ | srcLevel) & ~(srcQ & ~srcLevel);
    if (stb.wrForceHi) pendD[SRC_N-1:HALF] = wdata;
    if (stb.wrForceLo) pendD[HALF-1:0]     = wdata;
    if (stb.ackNorm && normHit) pendD[normIdx] = 1'b0;
    if (stb.ackFast && fastHit) pendD[fastIdx] = 1'b0;

    enD = enQ;
    if (stb.wrEnHi) enD[SRC_N-1:HALF] = wdata;
    if (stb.wrEnLo) enD[HALF-1:0]     = wdata;
    if (stb.enSet)  enD[wdata[IDX_W-1:0]] = 1'b1;
    if (stb.enClr)  enD[wdata[IDX_W-1:0]] = 1'b0;

    tyD = tyQ;
    if (stb.wrTyHi) tyD[SRC_N-1:HALF] = wdata;
    if (stb.wrTyLo) tyD[HALF-1:0]     = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      enQ    <= '0;
      tyQ    <= '0;
      srcQ   <= '0;
      thrQ   <= THR_OFF;
      ctrlQ  <= '0;
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
      for (int w = 0; w < PRIO_WORDS; w++) prioQ[w] <= '0;
    end else begin
      pendQ <= pendD;
      enQ   <= enD;
      tyQ   <= tyD;
      srcQ  <= srcLevel;
      if (stb.wrThr)  thrQ  <= wdata[THR_W-1:0];
      if (stb.wrCtrl) ctrlQ <= wdata[CTRL_W-1:0];
      if (stb.wrPrio) prioQ[stb.prioIdx] <= wdata;
      fiqOut <= |fastVec;
      irqOut <= (thrQ == THR_OFF) ? |normVec : |(normVec & aboveThr);
    end
  end

  always_comb begin
    case (stb.rdSel)
      RS_CTRL:     rdata = DATA_W'(ctrlQ);
      RS_THR:      rdata = DATA_W'(thrQ);
      RS_EN_HI:    rdata = enQ[SRC_N-1:HALF];
      RS_EN_LO:    rdata = enQ[HALF-1:0];
      RS_TY_HI:    rdata = tyQ[SRC_N-1:HALF];
      RS_TY_LO:    rdata = tyQ[HALF-1:0];
      RS_PRIO:     rdata = prioQ[stb.prioIdx];
      RS_NORM_VEC: rdata = normHit ? ((DATA_W'(normIdx) << 16) | DATA_W'(normPri)) : '1;
      RS_FAST_VEC: rdata = fastHit ? DATA_W'(fastIdx) : '1;
      RS_PEND_HI:  rdata = pendQ[SRC_N-1:HALF];
      RS_PEND_LO:  rdata = pendQ[HALF-1:0];
      RS_NPEND_HI: rdata = normVec[SRC_N-1:HALF];
      RS_NPEND_LO: rdata = normVec[HALF-1:0];
      RS_FPEND_HI: rdata = fastVec[SRC_N-1:HALF];
      RS_FPEND_LO: rdata = fastVec[HALF-1:0];
      RS_CONST4:   rdata = DATA_W'(4);
      default:     rdata = '0;
    endcase
  end

  AST_FAST_LINE_NEEDS_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> $past(|tyQ)); // R2

  AST_THR_BLOCKS_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (thrQ > 5'd15 && thrQ != THR_OFF) |=> !irqOut); // R4

  AST_ENABLE_BY_NUMBER: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> enQ[$past(wdata[IDX_W-1:0])]); // R5

  AST_NORM_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackNorm && normHit) |=> !pendQ[$past(normIdx)]); // R8

  AST_FAST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackFast && fastHit) |=> !pendQ[$past(fastIdx)]); // R9
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       srcLevel,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic              fiqOut
);
  strobe_t stb;

  irqc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  irqc_core #(.CTRL_W(CTRL_W)) uCore (
    .clk      (clk),
    .rstN     (rstN),
    .srcLevel (srcLevel),
    .stb      (stb),
    .wdata    (busWdata),
    .rdata    (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int PERIOD = 10;
  localparam int AW = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] srcLevel = '0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int nChk = 0;
  int nFail = 0;

  always #(PERIOD / 2) clk = ~clk;

  irqc_top #(.ADDR_W(AW), .CTRL_W(8)) u0 (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;   // write data, or expected read value
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 10'd2,   32'h0000_0045, 8'd5},   // R5 enable source 5
    '{1'b0, 10'd5,   32'h0000_0020, 8'd5},   // R5
    '{1'b0, 10'd2,   32'h0000_0000, 8'd5},   // R5 reads 0
    '{1'b1, 10'd3,   32'h0000_0005, 8'd5},   // R5 disable source 5
    '{1'b0, 10'd5,   32'h0000_0000, 8'd5},   // R5
    '{1'b0, 10'd3,   32'h0000_0000, 8'd5},   // R5
    '{1'b1, 10'd4,   32'hA5A5_0000, 8'd6},   // R6
    '{1'b0, 10'd4,   32'hA5A5_0000, 8'd6},   // R6
    '{1'b0, 10'd5,   32'h0000_0000, 8'd6},   // R6 low half untouched
    '{1'b1, 10'd5,   32'h0000_1234, 8'd6},   // R6
    '{1'b0, 10'd4,   32'hA5A5_0000, 8'd6},   // R6 high half untouched
    '{1'b1, 10'd6,   32'hFFFF_FFFF, 8'd6},   // R6
    '{1'b1, 10'd7,   32'h0000_000F, 8'd6},   // R6
    '{1'b0, 10'd6,   32'hFFFF_FFFF, 8'd6},   // R6
    '{1'b0, 10'd7,   32'h0000_000F, 8'd6},   // R6
    '{1'b1, 10'd0,   32'hFFFF_FFFF, 8'd13},  // R13
    '{1'b0, 10'd0,   32'h0000_00FF, 8'd13},  // R13
    '{1'b1, 10'd1,   32'h0000_00E6, 8'd14},  // R14
    '{1'b0, 10'd1,   32'h0000_0006, 8'd14},  // R14
    '{1'b1, 10'd8,   32'h1234_5678, 8'd7},   // R7
    '{1'b1, 10'd15,  32'h9ABC_DEF0, 8'd7},   // R7
    '{1'b0, 10'd8,   32'h1234_5678, 8'd7},   // R7
    '{1'b0, 10'd15,  32'h9ABC_DEF0, 8'd7},   // R7
    '{1'b0, 10'd16,  32'hFFFF_FFFF, 8'd8},   // R8 empty
    '{1'b0, 10'd17,  32'hFFFF_FFFF, 8'd9},   // R9 empty
    '{1'b0, 10'd21,  32'h0000_0000, 8'd10},  // R10 force reads 0
    '{1'b1, 10'd18,  32'h0000_FFFF, 8'd10},  // R10 ignored
    '{1'b0, 10'd18,  32'h0000_0000, 8'd10},  // R10
    '{1'b1, 10'h40,  32'h0000_0055, 8'd11},  // R11 ignored
    '{1'b0, 10'h40,  32'h0000_0004, 8'd11}   // R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; srcLevel = '0; busSel = 1'b0; busWr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(PERIOD * 50000);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    doReset();

    // R1: reset state
    @(negedge clk);
    check("R1 irqOut", {31'd0, irqOut}, 32'd0);
    check("R1 fiqOut", {31'd0, fiqOut}, 32'd0);
    readCheck(10'd1, 32'h1F, "R1 threshold");
    readCheck(10'd0, 32'h0, "R1 control");
    readCheck(10'd5, 32'h0, "R1 enable lo");
    readCheck(10'd6, 32'h0, "R1 type hi");
    readCheck(10'd19, 32'h0, "R1 pending lo");
    readCheck(10'd12, 32'h0, "R1 priority");

    // Table walk
    for (int k = 0; k < NV; k++) begin
      if (TBL[k].wr) busWrite(TBL[k].addr, TBL[k].data);
      else readCheck(TBL[k].addr, TBL[k].data, $sformatf("R%0d table %0d", TBL[k].req, k));
    end
    readCheck(10'hBF, 32'h0, "R11 vector region reads 0");
    busWrite(10'h80, 32'h0000_0003);
    readCheck(10'd15, 32'h9ABC_DEF0, "R11 region write left priority");
    readCheck(10'd0, 32'h0000_00FF, "R11 region write left control");

    // R12 and R2: source level, fast path, acknowledge race
    doReset();
    busWrite(10'd5, 32'h8);
    busWrite(10'd7, 32'h8);
    @(negedge clk); srcLevel[3] = 1'b1;
    @(negedge clk);
    readCheck(10'd19, 32'h8, "R12 level sets pending");
    check("R2 fast line high", {31'd0, fiqOut}, 32'd1);
    check("R3 normal line low for fast source", {31'd0, irqOut}, 32'd0);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 10'd17;
    #1 v = busRdata;
    check("R9 fast vector", v, 32'd3);
    @(negedge clk);
    busAddr = 10'd19;
    #1 v = busRdata;
    check("R12 ack clear wins", v, 32'd0);
    @(negedge clk);
    busSel = 1'b0;
    readCheck(10'd19, 32'h8, "R12 level sets again");
    @(negedge clk); srcLevel[3] = 1'b0;
    @(negedge clk);
    readCheck(10'd19, 32'h0, "R12 falling level clears");
    readCheck(10'd17, 32'hFFFF_FFFF, "R9 none left");
    @(negedge clk);
    check("R2 fast line low", {31'd0, fiqOut}, 32'd0);

    // R9: lowest fast source first
    doReset();
    busWrite(10'd5, 32'hFFFF_FFFF);
    busWrite(10'd7, 32'hFFFF_FFFF);
    busWrite(10'd21, 32'h0000_0050);
    readCheck(10'd17, 32'd4, "R9 lowest first");
    readCheck(10'd17, 32'd6, "R9 next");
    readCheck(10'd17, 32'hFFFF_FFFF, "R9 drained");

    // R8: priority, tie to higher index
    doReset();
    busWrite(10'd4, 32'hFFFF_FFFF);
    busWrite(10'd5, 32'hFFFF_FFFF);
    busWrite(10'd15, 32'h0000_0700);   // source 2 prio 7
    busWrite(10'd14, 32'h0000_0700);   // source 10 prio 7
    busWrite(10'd10, 32'h0000_0003);   // source 40 prio 3
    busWrite(10'd21, 32'h0000_0404);
    busWrite(10'd20, 32'h0000_0100);
    readCheck(10'd16, 32'h000A_0007, "R8 tie to higher index");
    readCheck(10'd16, 32'h0002_0007, "R8 second");
    readCheck(10'd16, 32'h0028_0003, "R8 lower priority (R7 map)");
    readCheck(10'd16, 32'hFFFF_FFFF, "R8 drained");

    // R3 / R4: threshold
    doReset();
    busWrite(10'd5, 32'hFFFF_FFFF);
    busWrite(10'd15, 32'h0000_0700);
    busWrite(10'd21, 32'h0000_0004);
    @(negedge clk);
    check("R3 threshold off", {31'd0, irqOut}, 32'd1);
    busWrite(10'd1, 32'd7);
    @(negedge clk);
    check("R4 equal priority blocked", {31'd0, irqOut}, 32'd0);
    busWrite(10'd1, 32'd6);
    @(negedge clk);
    check("R4 above threshold", {31'd0, irqOut}, 32'd1);
    busWrite(10'd1, 32'd20);
    @(negedge clk);
    check("R4 high threshold blocks", {31'd0, irqOut}, 32'd0);
    busWrite(10'd21, 32'h0000_0020);
    busWrite(10'd1, 32'h1F);
    @(negedge clk);
    check("R3 priority 0 passes", {31'd0, irqOut}, 32'd1);
    busWrite(10'd1, 32'd0);
    @(negedge clk);
    check("R4 priority 0 blocked", {31'd0, irqOut}, 32'd0);

    // R10: pending views
    doReset();
    busWrite(10'd21, 32'h3);
    busWrite(10'd20, 32'h80);
    busWrite(10'd5, 32'h3);
    busWrite(10'd4, 32'h80);
    busWrite(10'd7, 32'h2);
    readCheck(10'd19, 32'h3, "R10 raw lo");
    readCheck(10'd18, 32'h80, "R10 raw hi");
    readCheck(10'd23, 32'h1, "R10 normal lo");
    readCheck(10'd22, 32'h80, "R10 normal hi");
    readCheck(10'd25, 32'h2, "R10 fast lo");
    readCheck(10'd24, 32'h0, "R10 fast hi");
    readCheck(10'd20, 32'h0, "R10 force reads 0");
    busWrite(10'd23, 32'hFFFF_FFFF);
    busWrite(10'd16, 32'hFFFF_FFFF);
    readCheck(10'd19, 32'h3, "R10 writes ignored");
    readCheck(10'd5, 32'h3, "R10 enable untouched");

    finishRun();
  end
endmodule